// File: doc/BRIEF.md
# Flash Sector Map and Write-Lock Guard

This block sits beside the command state machine of a dual-plane NOR flash. It turns a 19-bit word address into one of 22 erase sectors and reports whether that sector is in the small-sector plane or the uniform plane. The decode is purely combinational. With the default bottom-boot layout, words 0x00000 to 0x0FFFF form the small plane with eight sectors. In address order their sizes are 8K, 16K, 4K, 4K, 4K, 4K, 16K and 8K words. Words 0x10000 to 0x7FFFF form the large plane with fourteen 32K-word sectors. A parameter can instead place the small plane at the top of the address space.

Each sector has one sticky lock bit. A strobe sets the bit, and any address inside the sector selects it. The bits are cleared only by the power-on initialisation input. A high-voltage override input re-opens locked sectors while it is held. The block also provides the following:
- a per-sector mask of what a chip erase may touch;
- the lock state of the addressed sector, for identification-mode reads at word offset 2 inside that sector;
- a fixed busy window that ends an erase request aimed at a protected sector without any effect.

Top module: `flash_sector_guard`

## Requirements
- R1: In the small plane (plane output 0), word addresses map to sectors 0..7 as follows: 0x00000-0x01FFF is sector 0, 0x02000-0x05FFF is sector 1, 0x06000, 0x07000, 0x08000 and 0x09000 start the 4K-word sectors 2 to 5, 0x0A000-0x0DFFF is sector 6, and 0x0E000-0x0FFFF is sector 7.
- R2: Addresses 0x10000-0x7FFFF set the plane output to 1 and select sector 8 + (address - 0x10000)/0x8000, giving sectors 8..21.
- R3: A `lock_set` pulse at a clock edge sets the lock bit of the sector that contains `lock_addr`, whatever the address is within that sector. The new state is visible after that edge, and no other sector's bit changes.
- R4: `acc_wr_ok` is 0 for a locked sector while `hv_ovr` is low, and 1 for an unlocked sector.
- R5: While `hv_ovr` is high, `acc_wr_ok` is 1 and every `erase_mask` bit is 1. Protection returns in the same cycle that `hv_ovr` drops.
- R6: Bit i of `erase_mask` is 1 exactly when sector i is unlocked or `hv_ovr` is high.
- R7: `id_hit` is 1 only when `acc_addr` is word offset 2 from its sector's base. `id_lock` then shows that sector's lock bit (1 means locked). `id_lock` is 0 whenever `id_hit` is 0.
- R8: If `rej_start` is sampled high while the addressed sector is locked, `hv_ovr` is low and no rejection is running, `rej_busy` is high for exactly REJ_CYC cycles. `rej_done` is then high for one cycle. A `rej_start` on a writable sector is ignored.
- R9: `rst_n` does not clear lock bits. A low `por_n` clears all of them.
- R10: After initialisation, no sector is locked, `erase_mask` is all ones, `rej_busy` is 0 and `rej_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the rejection timer |
| por_n | input | 1 | Synchronous active-low power-on clear of all lock bits |
| hv_ovr | input | 1 | High-voltage override; locked sectors become writable while it is high |
| acc_addr | input | 19 | Word address of the current access |
| acc_sect | output | 5 | Sector index of `acc_addr` |
| acc_plane | output | 1 | 0 = small-sector plane, 1 = uniform plane |
| acc_wr_ok | output | 1 | The addressed sector may be programmed or erased |
| id_hit | output | 1 | `acc_addr` is word offset 2 within its sector |
| id_lock | output | 1 | Lock state for an identification read (valid when `id_hit` is 1) |
| lock_set | input | 1 | Strobe that locks the sector containing `lock_addr` |
| lock_addr | input | 19 | Any word address inside the sector to lock |
| erase_mask | output | 22 | Sectors that a chip erase may change |
| rej_start | input | 1 | Erase request for the sector at `acc_addr` |
| rej_busy | output | 1 | Busy window of a rejected erase |
| rej_done | output | 1 | One-cycle end of a rejected erase |

## Verification
The address decode, `acc_wr_ok`, `id_hit`, `id_lock` and `erase_mask` are combinational from the inputs and the lock bits. The bench therefore drives inputs on the falling edge and reads these outputs 2 ns later in the same cycle. A lock strobe takes effect at the next rising edge, so the checks that depend on it read the outputs at the falling edge after that edge. The rejection busy signal rises at the edge that samples `rej_start`. The bench counts high cycles on each following falling edge and expects `rej_done` on the falling edge where busy is first seen low.

// File: rtl/sg_pkg.sv
// Shared constants, types and layout helpers for the sector guard.
// Assumes 4K-word granularity inside the small plane and 32K-word sectors in the large plane.
package sg_pkg;
    localparam int ADDR_W   = 19;
    localparam int NSECT    = 22;
    localparam int SMALL_N  = 8;
    localparam int SMALL_SH = 16;
    localparam int BIG_SH   = 15;
    localparam int UNIT_SH  = 12;
    localparam int SIDX_W   = $clog2(NSECT);
    localparam int BIG_N    = NSECT - SMALL_N;
    localparam int BIG_IDX_W = ADDR_W - BIG_SH;
    localparam int SKIP_BIG  = 1 << (SMALL_SH - BIG_SH);

    typedef logic [SIDX_W-1:0] sidx_t;
    typedef logic [ADDR_W-1:0] waddr_t;

    // Small-plane slot for a 4K-word unit number (layout 2,4,1,1,1,1,4,2 units).
    function automatic logic [2:0] small_slot(input logic [3:0] unit);
        logic [2:0] s;
        case (unit)
            4'd0, 4'd1:                s = 3'd0;
            4'd2, 4'd3, 4'd4, 4'd5:    s = 3'd1;
            4'd6:                      s = 3'd2;
            4'd7:                      s = 3'd3;
            4'd8:                      s = 3'd4;
            4'd9:                      s = 3'd5;
            4'd10, 4'd11, 4'd12, 4'd13: s = 3'd6;
            default:                   s = 3'd7;
        endcase
        return s;
    endfunction

    // First 4K-word unit of a small-plane slot.
    function automatic logic [3:0] small_base(input logic [2:0] slot);
        logic [3:0] u;
        case (slot)
            3'd0: u = 4'd0;
            3'd1: u = 4'd2;
            3'd2: u = 4'd6;
            3'd3: u = 4'd7;
            3'd4: u = 4'd8;
            3'd5: u = 4'd9;
            3'd6: u = 4'd10;
            default: u = 4'd14;
        endcase
        return u;
    endfunction
endpackage

// File: rtl/sg_decode.sv
// Combinational word-address to sector decode.
// Produces the sector index, the plane (0 small, 1 uniform) and the sector base address.
// TOP_BOOT=0 places the small plane at address 0, TOP_BOOT=1 at the top of the space.
module sg_decode
    import sg_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b0
) (
    input  waddr_t addr,
    output sidx_t  sect,
    output logic   plane,
    output waddr_t base
);
    localparam int HI_W = ADDR_W - SMALL_SH;

    logic [BIG_IDX_W-1:0] big_idx;
    logic [3:0]           unit;
    logic [2:0]           slot;
    logic [HI_W-1:0]      hi;

    assign big_idx = addr[ADDR_W-1:BIG_SH];
    assign unit    = addr[SMALL_SH-1:UNIT_SH];
    assign hi      = addr[ADDR_W-1:SMALL_SH];
    assign slot    = small_slot(unit);

    generate
        if (TOP_BOOT) begin : g_top
            // Small plane occupies the highest 64K words; large sectors number from 0.
            always_comb begin
                if (hi == {HI_W{1'b1}}) begin
                    plane = 1'b0;
                    sect  = sidx_t'(BIG_N) + sidx_t'(slot);
                    base  = {hi, small_base(slot), {UNIT_SH{1'b0}}};
                end else begin
                    plane = 1'b1;
                    sect  = sidx_t'(big_idx);
                    base  = {big_idx, {BIG_SH{1'b0}}};
                end
            end
        end else begin : g_bottom
            // Small plane occupies the lowest 64K words; large sectors follow from index 8.
            always_comb begin
                if (hi == '0) begin
                    plane = 1'b0;
                    sect  = sidx_t'(slot);
                    base  = {hi, small_base(slot), {UNIT_SH{1'b0}}};
                end else begin
                    plane = 1'b1;
                    sect  = sidx_t'(big_idx) + sidx_t'(SMALL_N - SKIP_BIG);
                    base  = {big_idx, {BIG_SH{1'b0}}};
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sg_lock_bank.sv
// Sticky per-sector lock bits with override-aware query and chip-erase mask.
// Assumes set_idx comes from the same decode as the query path; only por_n clears bits.
module sg_lock_bank
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              hv_ovr,
    input  logic              set_en,
    input  sidx_t             set_idx,
    input  sidx_t             q_idx,
    output logic              q_locked,
    output logic [NSECT-1:0]  erase_mask
);
    logic [NSECT-1:0] locks;

    // Lock register: cleared by power-on only, set by strobe.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            locks <= '0;
        end else if (set_en && (int'(set_idx) < NSECT)) begin
            locks[set_idx] <= 1'b1;
        end
    end

    // Query the lock bit of the addressed sector.
    always_comb begin
        q_locked = (int'(q_idx) < NSECT) ? locks[q_idx] : 1'b0;
    end

    // Chip erase may touch every unlocked sector, or all sectors under override.
    always_comb begin
        erase_mask = ~locks | {NSECT{hv_ovr}};
    end

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> ((locks & $past(locks)) == $past(locks)));

    // R3
    lock_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        (set_en && (int'(set_idx) < NSECT)) |=> locks[$past(set_idx)]);
endmodule

// File: rtl/sg_reject_timer.sv
// Fixed busy window for an erase aimed at a protected sector.
// Assumes blocked is valid in the cycle rej_start is high; requests during a window are dropped.
module sg_reject_timer #(
    parameter int REJ_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic blocked,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(REJ_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Countdown of the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (start && blocked) begin
            cnt <= CNT_W'(REJ_CYC);
        end
    end

    // One-cycle completion flag after the last busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (cnt == CNT_W'(1));
        end
    end

    assign busy = (cnt != '0);

    // R8
    rej_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && blocked && !busy) |=> busy);

    // R8
    rej_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/flash_sector_guard.sv
// Top level: sector decode for access and lock paths, lock bank, identification
// lock read at word offset 2, and rejection timer for erases on protected sectors.
// Assumes synchronous active-low rst_n and por_n; outputs other than rej_* are combinational.
module flash_sector_guard
    import sg_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b0,
    parameter int REJ_CYC  = 100,
    parameter int ID_OFS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              hv_ovr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [SIDX_W-1:0] acc_sect,
    output logic              acc_plane,
    output logic              acc_wr_ok,
    output logic              id_hit,
    output logic              id_lock,
    input  logic              lock_set,
    input  logic [ADDR_W-1:0] lock_addr,
    output logic [NSECT-1:0]  erase_mask,
    input  logic              rej_start,
    output logic              rej_busy,
    output logic              rej_done
);
    waddr_t acc_base;
    waddr_t lk_base;
    sidx_t  lk_sect;
    logic   lk_plane;
    logic   acc_locked;

    sg_decode #(.TOP_BOOT(TOP_BOOT)) acc_dec_i (
        .addr(acc_addr), .sect(acc_sect), .plane(acc_plane), .base(acc_base)
    );

    sg_decode #(.TOP_BOOT(TOP_BOOT)) lk_dec_i (
        .addr(lock_addr), .sect(lk_sect), .plane(lk_plane), .base(lk_base)
    );

    sg_lock_bank bank_i (
        .clk(clk), .por_n(por_n), .hv_ovr(hv_ovr),
        .set_en(lock_set), .set_idx(lk_sect),
        .q_idx(acc_sect), .q_locked(acc_locked),
        .erase_mask(erase_mask)
    );

    // Write permission and identification lock read for the access address.
    always_comb begin
        acc_wr_ok = !acc_locked || hv_ovr;
        id_hit    = ((acc_addr - acc_base) == waddr_t'(ID_OFS));
        id_lock   = id_hit && acc_locked;
    end

    sg_reject_timer #(.REJ_CYC(REJ_CYC)) rej_i (
        .clk(clk), .rst_n(rst_n), .start(rej_start),
        .blocked(!acc_wr_ok), .busy(rej_busy), .done(rej_done)
    );

    // R1 R2
    sect_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        (int'(acc_sect) < NSECT) && (int'(lk_sect) < NSECT) && (lk_plane == lk_plane));

    // R6
    wr_ok_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
        erase_mask[acc_sect] == acc_wr_ok);
endmodule

// File: tb/flash_sector_guard_tb_top.sv
module flash_sector_guard_tb_top;
    localparam int REJ = 100;
    localparam int NV  = 21;
    // Vector: [31] id_hit, [30] plane, [28:24] sector, [18:0] word address
    localparam logic [31:0] VEC [NV] = '{
        32'h0000_0000, 32'h8000_0002, 32'h0000_1FFF, 32'h0100_2000,
        32'h0100_5FFF, 32'h0200_6000, 32'h8200_6002, 32'h0300_7000,
        32'h0400_8FFF, 32'h0500_9000, 32'h0600_A000, 32'h0600_DFFF,
        32'h0700_E000, 32'h0700_FFFF, 32'h4801_0000, 32'hC801_0002,
        32'h4801_7FFF, 32'h4901_8000, 32'h4E04_3210, 32'h5507_FFFF,
        32'hD407_0002
    };

    logic clk = 1'b0;
    logic rst_n, por_n, hv_ovr, lock_set, rej_start;
    logic [18:0] acc_addr, lock_addr;
    logic [4:0] acc_sect;
    logic acc_plane, acc_wr_ok, id_hit, id_lock, rej_busy, rej_done;
    logic [21:0] erase_mask;
    int n_chk = 0, n_bad = 0;
    bit wd_fired = 1'b0;

    always #10 clk = ~clk;

    flash_sector_guard dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .hv_ovr(hv_ovr),
        .acc_addr(acc_addr), .acc_sect(acc_sect), .acc_plane(acc_plane),
        .acc_wr_ok(acc_wr_ok), .id_hit(id_hit), .id_lock(id_lock),
        .lock_set(lock_set), .lock_addr(lock_addr), .erase_mask(erase_mask),
        .rej_start(rej_start), .rej_busy(rej_busy), .rej_done(rej_done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [18:0] a);
        @(negedge clk);
        acc_addr = a;
        #2;
    endtask

    initial begin
        #3_000_000;
        wd_fired = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        rst_n = 0; por_n = 0; hv_ovr = 0; lock_set = 0; rej_start = 0;
        acc_addr = '0; lock_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;

        // R10 reset state
        look(19'h07000);
        chk(erase_mask == '1, "R10 mask", erase_mask, 22'h3FFFFF);
        chk(acc_wr_ok == 1'b1, "R10 wr_ok", acc_wr_ok, 1);
        chk(rej_busy == 1'b0 && rej_done == 1'b0, "R10 rej", {rej_busy, rej_done}, 0);

        // R1 R2 R7 decode table
        for (int i = 0; i < NV; i++) begin
            look(VEC[i][18:0]);
            chk(acc_sect == VEC[i][28:24], VEC[i][30] ? "R2 sect" : "R1 sect", acc_sect, VEC[i][28:24]);
            chk(acc_plane == VEC[i][30], VEC[i][30] ? "R2 plane" : "R1 plane", acc_plane, VEC[i][30]);
            chk(id_hit == VEC[i][31], "R7 id_hit", id_hit, VEC[i][31]);
            chk(id_lock == 1'b0, "R7 id_lock unlocked", id_lock, 0);
        end

        // R3 lock sector 3 via a mid-sector address
        @(negedge clk);
        lock_addr = 19'h07123; lock_set = 1;
        @(negedge clk);
        lock_set = 0;
        look(19'h07000);
        chk(acc_wr_ok == 1'b0, "R3 R4 locked sector", acc_wr_ok, 0);
        look(19'h06FFF);
        chk(acc_wr_ok == 1'b1, "R3 neighbour open", acc_wr_ok, 1);
        chk(erase_mask == ~(22'd1 << 3), "R6 mask one lock", erase_mask, ~(22'd1 << 3));

        // R7 identification read
        look(19'h07002);
        chk(id_hit && id_lock, "R7 locked id", {id_hit, id_lock}, 2'b11);
        look(19'h06002);
        chk(id_hit && !id_lock, "R7 open id", {id_hit, id_lock}, 2'b10);

        // R5 override on and off
        @(negedge clk);
        hv_ovr = 1; acc_addr = 19'h07000;
        #2;
        chk(acc_wr_ok == 1'b1, "R5 ovr wr_ok", acc_wr_ok, 1);
        chk(erase_mask == '1, "R5 ovr mask", erase_mask, 22'h3FFFFF);
        @(negedge clk);
        hv_ovr = 0;
        #2;
        chk(acc_wr_ok == 1'b0, "R5 ovr removed", acc_wr_ok, 0);

        // R3 R6 lock last sector
        @(negedge clk);
        lock_addr = 19'h7ABCD; lock_set = 1;
        @(negedge clk);
        lock_set = 0;
        #2;
        chk(erase_mask == ~((22'd1 << 3) | (22'd1 << 21)), "R6 mask two locks",
            erase_mask, ~((22'd1 << 3) | (22'd1 << 21)));

        // R8 rejected erase on locked sector
        @(negedge clk);
        acc_addr = 19'h07000; rej_start = 1;
        @(negedge clk);
        rej_start = 0;
        cnt = 0;
        while (rej_busy && cnt < REJ + 5) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == REJ, "R8 busy length", cnt, REJ);
        chk(rej_done == 1'b1, "R8 done pulse", rej_done, 1);
        @(negedge clk);
        chk(rej_done == 1'b0, "R8 done one cycle", rej_done, 0);

        // R8 request on open sector ignored
        acc_addr = 19'h00000; rej_start = 1;
        @(negedge clk);
        rej_start = 0;
        chk(rej_busy == 1'b0, "R8 open ignored", rej_busy, 0);

        // R8 request under override ignored
        acc_addr = 19'h07000; hv_ovr = 1; rej_start = 1;
        @(negedge clk);
        rej_start = 0; hv_ovr = 0;
        chk(rej_busy == 1'b0, "R8 ovr ignored", rej_busy, 0);

        // R9 reset keeps locks, power-on clears them
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #2;
        chk(acc_wr_ok == 1'b0, "R9 rst keeps lock", acc_wr_ok, 0);
        @(negedge clk);
        por_n = 0;
        @(negedge clk);
        por_n = 1;
        #2;
        chk(erase_mask == '1 && acc_wr_ok, "R9 por clears", erase_mask, 22'h3FFFFF);

        if (!wd_fired) begin
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule